// File: doc/BRIEF.md
# Credit-Gated Virtual Channel Receiver

This block handles the receive side of one point-to-point link that carries eight independent virtual channels. On each channel, software first opens the channel with two registration steps. One step grants the channel the whole local memory as its receive region. The other step registers the channel's notification buffer. After that, software posts receive credits. A credit names a destination address, a length in bytes and a slot in that channel's notification buffer. Each channel queues its credits in order of posting, up to four at a time.

Payload arrives as beats. Each beat carries a channel number, a word offset, 64 data bits and an end-of-message marker. A beat is matched to the oldest credit still outstanding on its channel. Its data is written to local memory at the credit address plus the offset. When the end-of-message beat has been handled, the credit is retired and its notification slot is marked done. A thread that blocks on a slot is modelled by the `wait_done` status output. This output reads the slot selected by `wait_vc` and `wait_idx`. Beats with no credit to consume, and beats that fall outside their credit, are dropped. Each such event sets a sticky per-channel flag. Traffic on the other channels carries on unaffected.

Top module: `vc_credit_rx`

## Requirements
- R1: After reset, no write is issued, `cr_reject` is low, all overflow and error flags are 0, and every notification slot reads not done.
- R2: A credit posted on a channel that lacks either registration (`reg_notify`=0 region grant, `reg_notify`=1 notification buffer) is refused: `cr_reject` is high in the cycle after the post, and the credit is not queued.
- R3: A credit is refused unless its address has bits [6:0] zero, its size is a nonzero multiple of 128, and address plus size does not exceed 2^18.
- R4: A channel holds at most four outstanding credits, and a fifth post on that channel is refused.
- R5: A beat that finds a credit and fits inside it produces `wr_en` in the next cycle, with `wr_addr` = credit address + 8*`pkt_off` and `wr_data` = `pkt_data`.
- R6: Credits on a channel are consumed in the order they were posted, and each channel's credits are consumed only by beats on that channel.
- R7: A beat on a channel with no outstanding credit sets that channel's bit in `ovf_flags`, which then stays set, and it causes no write. Other channels keep working.
- R8: A beat with 8*`pkt_off`+8 greater than the credit size sets that channel's bit in `err_flags`, which then stays set, and it causes no write.
- R9: A beat with `pkt_last`=1 that finds a credit retires that credit, even if its data was out of range. From the next cycle, the credit's slot reads done on `wait_done`.
- R10: Posting an accepted credit clears the done mark of the slot it names, starting from the next cycle.
- R11: A registration, or a credit, takes effect from the cycle after the one in which it is presented. Registrations stay in force until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Registration strobe |
| reg_vc | input | 3 | Channel being registered |
| reg_notify | input | 1 | 0: grant receive region, 1: register notification buffer |
| cr_valid | input | 1 | Credit post strobe |
| cr_vc | input | 3 | Channel of the credit |
| cr_addr | input | 18 | Destination byte address |
| cr_size | input | 19 | Credit length in bytes |
| cr_nidx | input | 3 | Notification slot of the credit |
| cr_reject | output | 1 | Previous cycle's credit post was refused |
| pkt_valid | input | 1 | Payload beat strobe |
| pkt_vc | input | 3 | Channel of the beat |
| pkt_off | input | 15 | Offset in 8-byte words inside the credit |
| pkt_data | input | 64 | Beat payload |
| pkt_last | input | 1 | Beat ends the message |
| wr_en | output | 1 | Local memory write strobe |
| wr_addr | output | 18 | Local memory byte address |
| wr_data | output | 64 | Local memory write data |
| ovf_flags | output | 8 | Sticky per-channel overflow flags for beats with no credit |
| err_flags | output | 8 | Sticky per-channel range-error flags |
| wait_vc | input | 3 | Channel of the slot being waited on |
| wait_idx | input | 3 | Slot being waited on |
| wait_done | output | 1 | Selected slot is marked done |

## Verification
A credit queue that drops an entry, duplicates one or reorders them shows up at the ports one cycle after the next beat on that channel. In that case `wr_addr` shows the wrong base, or an overflow flag is set while credits are still outstanding. A notification table entry that is set or cleared at the wrong slot shows up on `wait_done` in the very next cycle, whenever that slot is selected. The stimulus therefore interleaves posts, beats and slot queries across all channels, so that queue or slot damage is caught within a few operations. The stimulus also includes full queues, misaligned or oversized credits, and beats that run past the end of their credit.

// File: rtl/vcrx_pkg.sv
package vcrx_pkg;
  localparam int ADDR_W     = 18;
  localparam int SIZE_W     = ADDR_W + 1;
  localparam int DATA_W     = 64;
  localparam int BEAT_LOG2  = 3;
  localparam int OFF_W      = ADDR_W - BEAT_LOG2;
  localparam int BLK_LOG2   = 7;
  localparam int NIDX_DEPTH = 8;
  localparam int NIDX_W     = $clog2(NIDX_DEPTH);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [SIZE_W-1:0] size;
    logic [NIDX_W-1:0] nidx;
  } credit_t;

  function automatic logic credit_shape_ok(input logic [ADDR_W-1:0] addr,
                                           input logic [SIZE_W-1:0] size);
    logic [SIZE_W:0] end_sum;
    end_sum = {2'b00, addr} + {1'b0, size};
    return (addr[BLK_LOG2-1:0] == '0) && (size[BLK_LOG2-1:0] == '0) &&
           (size != '0) && (end_sum <= ({{SIZE_W{1'b0}}, 1'b1} << ADDR_W));
  endfunction

  function automatic logic beat_fits(input logic [OFF_W-1:0] off,
                                     input logic [SIZE_W-1:0] size);
    logic [SIZE_W:0] last_byte;
    last_byte = {2'b00, off, {BEAT_LOG2{1'b0}}} + (SIZE_W+1)'(1 << BEAT_LOG2);
    return last_byte <= {1'b0, size};
  endfunction

  function automatic logic [ADDR_W-1:0] beat_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [OFF_W-1:0] off);
    return base + {off, {BEAT_LOG2{1'b0}}};
  endfunction
endpackage

// File: rtl/vcrx_credit_fifo.sv
module vcrx_credit_fifo
  import vcrx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    push,
  input  credit_t push_data,
  input  logic    pop,
  output credit_t head,
  output logic    empty,
  output logic    full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  credit_t             slots [DEPTH];
  logic [PTR_W-1:0]    rd_ptr, wr_ptr;
  logic [CNT_W-1:0]    count;

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign head  = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        slots[wr_ptr] <= push_data;
        wr_ptr        <= next_ptr(wr_ptr);
      end
      if (pop) rd_ptr <= next_ptr(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  a_r4_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  a_r6_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  a_r6_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/vcrx_notify_table.sv
module vcrx_notify_table
  import vcrx_pkg::*;
#(
  parameter int NUM_VC = 8,
  parameter int VC_W   = $clog2(NUM_VC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_en,
  input  logic [VC_W-1:0]   clr_vc,
  input  logic [NIDX_W-1:0] clr_idx,
  input  logic              set_en,
  input  logic [VC_W-1:0]   set_vc,
  input  logic [NIDX_W-1:0] set_idx,
  input  logic [VC_W-1:0]   rd_vc,
  input  logic [NIDX_W-1:0] rd_idx,
  output logic              rd_done
);
  localparam int SLOTS = NUM_VC * NIDX_DEPTH;
  localparam int SEL_W = VC_W + NIDX_W;

  logic [SLOTS-1:0] done_q;
  logic [SEL_W-1:0] clr_sel, set_sel, rd_sel;

  assign clr_sel = {clr_vc, clr_idx};
  assign set_sel = {set_vc, set_idx};
  assign rd_sel  = {rd_vc, rd_idx};
  assign rd_done = done_q[rd_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= '0;
    end else begin
      if (clr_en) done_q[clr_sel] <= 1'b0;
      if (set_en) done_q[set_sel] <= 1'b1;
    end
  end

  a_r9_set_visible: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> done_q[$past(set_sel)]);
  a_r10_clear_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(set_en && set_sel == clr_sel)) |=> !done_q[$past(clr_sel)]);
endmodule

// File: rtl/vc_credit_rx.sv
module vc_credit_rx
  import vcrx_pkg::*;
#(
  parameter int NUM_VC       = 8,
  parameter int CREDIT_DEPTH = 4,
  parameter int VC_W         = $clog2(NUM_VC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic [VC_W-1:0]   reg_vc,
  input  logic              reg_notify,
  input  logic              cr_valid,
  input  logic [VC_W-1:0]   cr_vc,
  input  logic [ADDR_W-1:0] cr_addr,
  input  logic [SIZE_W-1:0] cr_size,
  input  logic [NIDX_W-1:0] cr_nidx,
  output logic              cr_reject,
  input  logic              pkt_valid,
  input  logic [VC_W-1:0]   pkt_vc,
  input  logic [OFF_W-1:0]  pkt_off,
  input  logic [DATA_W-1:0] pkt_data,
  input  logic              pkt_last,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [NUM_VC-1:0] ovf_flags,
  output logic [NUM_VC-1:0] err_flags,
  input  logic [VC_W-1:0]   wait_vc,
  input  logic [NIDX_W-1:0] wait_idx,
  output logic              wait_done
);
  logic [NUM_VC-1:0] region_q, notif_q;
  logic [NUM_VC-1:0] fifo_empty, fifo_full, fifo_push, fifo_pop;
  credit_t           fifo_head [NUM_VC];
  credit_t           new_credit, hit_credit;

  logic ev_accept, ev_reject, ev_hit, ev_miss, ev_fit, ev_range_err, ev_complete;

  assign new_credit = '{addr: cr_addr, size: cr_size, nidx: cr_nidx};
  assign ev_reject  = cr_valid && (!region_q[cr_vc] || !notif_q[cr_vc] ||
                                   fifo_full[cr_vc] || !credit_shape_ok(cr_addr, cr_size));
  assign ev_accept  = cr_valid && !ev_reject;

  assign hit_credit   = fifo_head[pkt_vc];
  assign ev_hit       = pkt_valid && !fifo_empty[pkt_vc];
  assign ev_miss      = pkt_valid && fifo_empty[pkt_vc];
  assign ev_fit       = ev_hit && beat_fits(pkt_off, hit_credit.size);
  assign ev_range_err = ev_hit && !beat_fits(pkt_off, hit_credit.size);
  assign ev_complete  = ev_hit && pkt_last;

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    assign fifo_push[v] = ev_accept && (cr_vc == VC_W'(v));
    assign fifo_pop[v]  = ev_complete && (pkt_vc == VC_W'(v));
    vcrx_credit_fifo #(.DEPTH(CREDIT_DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (fifo_push[v]),
      .push_data (new_credit),
      .pop       (fifo_pop[v]),
      .head      (fifo_head[v]),
      .empty     (fifo_empty[v]),
      .full      (fifo_full[v])
    );
  end

  vcrx_notify_table #(.NUM_VC(NUM_VC), .VC_W(VC_W)) u_notify (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_en  (ev_accept),
    .clr_vc  (cr_vc),
    .clr_idx (cr_nidx),
    .set_en  (ev_complete),
    .set_vc  (pkt_vc),
    .set_idx (hit_credit.nidx),
    .rd_vc   (wait_vc),
    .rd_idx  (wait_idx),
    .rd_done (wait_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      region_q  <= '0;
      notif_q   <= '0;
      cr_reject <= 1'b0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      ovf_flags <= '0;
      err_flags <= '0;
    end else begin
      if (reg_valid && !reg_notify) region_q[reg_vc] <= 1'b1;
      if (reg_valid &&  reg_notify) notif_q[reg_vc]  <= 1'b1;
      cr_reject <= ev_reject;
      wr_en     <= ev_fit;
      if (ev_fit) begin
        wr_addr <= beat_addr(hit_credit.addr, pkt_off);
        wr_data <= pkt_data;
      end
      if (ev_miss)      ovf_flags[pkt_vc] <= 1'b1;
      if (ev_range_err) err_flags[pkt_vc] <= 1'b1;
    end
  end

  a_r2_unregistered_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_valid && !(region_q[cr_vc] && notif_q[cr_vc])) |=> cr_reject);
  a_r5_write_needs_beat: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(pkt_valid));
  a_r7_miss_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> !wr_en);
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flags & $past(ovf_flags)) == $past(ovf_flags));
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags & $past(err_flags)) == $past(err_flags));
  a_r8_range_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    ev_range_err |=> !wr_en);
  a_r9_complete_pops: assert property (@(posedge clk) disable iff (!rst_n)
    ev_complete |-> $onehot(fifo_pop));
endmodule

// File: tb/vc_credit_rx_bench.sv
module vc_credit_rx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        reg_valid = 0, reg_notify = 0, cr_valid = 0, pkt_valid = 0, pkt_last = 0;
  logic [2:0]  reg_vc = 0, cr_vc = 0, cr_nidx = 0, pkt_vc = 0, wait_vc = 0, wait_idx = 0;
  logic [17:0] cr_addr = 0;
  logic [18:0] cr_size = 0;
  logic [14:0] pkt_off = 0;
  logic [63:0] pkt_data = 0;
  logic        cr_reject, wr_en, wait_done;
  logic [17:0] wr_addr;
  logic [63:0] wr_data;
  logic [7:0]  ovf_flags, err_flags;

  vc_credit_rx u_vc_credit_rx (.*);

  int checks = 0, fails = 0;
  bit m_reg [8], m_ntf [8];
  int m_addr [8][4], m_size [8][4], m_nidx [8][4], m_cnt [8];
  bit m_done [8][8];
  logic [7:0] m_ovf = 0, m_err = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_refuse(int vc, int addr, int size);
    if (!(m_reg[vc] && m_ntf[vc])) return 1;
    if (addr % 128 != 0 || size % 128 != 0 || size == 0) return 1;
    if (addr + size > 262144) return 1;
    return m_cnt[vc] == 4;
  endfunction

  task automatic do_reg(int vc, bit ntf);
    @(negedge clk);
    reg_valid = 1; reg_vc = 3'(vc); reg_notify = ntf;
    @(negedge clk);
    reg_valid = 0;
    if (ntf) m_ntf[vc] = 1; else m_reg[vc] = 1;
  endtask

  task automatic post(int vc, int addr, int size, int nidx, string req);
    bit refuse;
    refuse = exp_refuse(vc, addr, size);
    @(negedge clk);
    cr_valid = 1; cr_vc = 3'(vc); cr_addr = 18'(addr); cr_size = 19'(size); cr_nidx = 3'(nidx);
    @(posedge clk); #2;
    cr_valid = 0;
    chk(cr_reject == refuse, req, "cr_reject", cr_reject, refuse);
    if (!refuse) begin
      m_addr[vc][m_cnt[vc]] = addr; m_size[vc][m_cnt[vc]] = size;
      m_nidx[vc][m_cnt[vc]] = nidx; m_cnt[vc]++;
      m_done[vc][nidx] = 0;
    end
  endtask

  task automatic beat(int vc, int off, logic [63:0] data, bit last, string req);
    bit exp_wr; int exp_a;
    exp_wr = 0; exp_a = 0;
    if (m_cnt[vc] == 0) m_ovf[vc] = 1;
    else begin
      if (off * 8 + 8 <= m_size[vc][0]) begin
        exp_wr = 1; exp_a = m_addr[vc][0] + off * 8;
      end else m_err[vc] = 1;
      if (last) begin
        m_done[vc][m_nidx[vc][0]] = 1;
        for (int k = 0; k < 3; k++) begin
          m_addr[vc][k] = m_addr[vc][k+1]; m_size[vc][k] = m_size[vc][k+1];
          m_nidx[vc][k] = m_nidx[vc][k+1];
        end
        m_cnt[vc]--;
      end
    end
    @(negedge clk);
    pkt_valid = 1; pkt_vc = 3'(vc); pkt_off = 15'(off); pkt_data = data; pkt_last = last;
    @(posedge clk); #2;
    pkt_valid = 0; pkt_last = 0;
    chk(wr_en == exp_wr, req, "wr_en", wr_en, exp_wr);
    if (exp_wr) begin
      chk(wr_addr == 18'(exp_a), req, "wr_addr", wr_addr, exp_a);
      chk(wr_data == data, req, "wr_data", wr_data, data);
    end
    chk(ovf_flags == m_ovf, req, "ovf_flags", ovf_flags, m_ovf);
    chk(err_flags == m_err, req, "err_flags", err_flags, m_err);
  endtask

  task automatic probe(int vc, int idx, string req);
    wait_vc = 3'(vc); wait_idx = 3'(idx);
    #1;
    chk(wait_done == m_done[vc][idx], req, "wait_done", wait_done, m_done[vc][idx]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R1: reset state
    chk(wr_en == 0, "R1", "wr_en", wr_en, 0);
    chk(cr_reject == 0, "R1", "cr_reject", cr_reject, 0);
    chk(ovf_flags == 0 && err_flags == 0, "R1", "flags", {ovf_flags, err_flags}, 0);
    for (int v = 0; v < 8; v++)
      for (int i = 0; i < 8; i++) probe(v, i, "R1");

    // R2 / R11: registration order
    post(0, 256, 128, 1, "R2");
    do_reg(0, 0);
    post(0, 256, 128, 1, "R2");
    do_reg(0, 1);
    post(0, 256, 128, 1, "R11");
    for (int v = 1; v < 8; v++) begin do_reg(v, 0); do_reg(v, 1); end

    // R3: shape checks
    post(3, 100, 128, 0, "R3");
    post(3, 128, 200, 0, "R3");
    post(3, 128, 0, 0, "R3");
    post(3, 262144 - 128, 256, 0, "R3");
    post(3, 262144 - 128, 128, 0, "R3");

    // R4: queue depth
    post(1, 1024, 256, 2, "R4");
    post(1, 4096, 128, 3, "R4");
    post(1, 8192, 128, 2, "R4");
    post(1, 16384, 128, 5, "R4");
    post(1, 32768, 128, 6, "R4");

    // R7: no credit on channel 2, other channels continue
    beat(2, 0, 64'hdead, 0, "R7");
    beat(1, 3, 64'h1111, 0, "R7");
    probe(2, 0, "R7");

    // R5 / R8 / R9 / R6 on channel 1
    beat(1, 31, 64'h2222, 0, "R5");
    beat(1, 32, 64'h3333, 0, "R8");
    probe(1, 2, "R9");
    beat(1, 0, 64'h4444, 1, "R9");
    probe(1, 2, "R9");
    beat(1, 1, 64'h5555, 1, "R6");
    probe(1, 3, "R9");
    beat(1, 16, 64'h6666, 1, "R8");
    probe(1, 2, "R8");

    // R10: reposting at a done slot clears it
    post(1, 65536, 128, 3, "R10");
    probe(1, 3, "R10");

    // Random traffic
    for (int n = 0; n < 600; n++) begin
      int op, vc, addr, size, off;
      op = $urandom % 3; vc = $urandom % 8;
      if (op == 0) begin
        addr = ($urandom % 2048) * 128 + (($urandom % 8 == 0) ? 64 : 0);
        size = (1 + $urandom % 4) * 128;
        post(vc, addr, size, $urandom % 8, "R6");
      end else begin
        off = $urandom % 72;
        beat(vc, off, {$urandom, $urandom}, ($urandom % 3) == 0, "R6");
      end
      probe($urandom % 8, $urandom % 8, "R9");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule